// File: doc/BRIEF.md
# Programmed-I/O Host Cycle Sequencer

This block sits on the host side of a 16-bit parallel disk interface and runs one programmed-I/O transfer per request. A request brings a register address, two active-high chip selects, a direction, write data, a flag that marks an 8-bit register access, and a transfer mode from 0 to 6. The block drives the address and selects, and then a read or write strobe. It holds the strobe for the mode's minimum active time and releases it. It keeps the address, the selects and any write data in place through a recovery phase, so that the hold time is met and the cycle from start to end meets the mode's minimum length. Every duration is a nanosecond figure rounded up to whole clock periods at elaboration.

In modes 0 to 4 the device can stretch the strobe through its ready line. The block synchronises that line and samples it a fixed time after the strobe falls. If the line is low, the strobe stays asserted until the line returns high. If the line stays low past the longest wait the interface allows, the block ends the cycle on its own and flags a timeout. Read data is taken from the bus as the strobe releases and is returned with a one-cycle done pulse.

Top module: `pio_cycle_ctrl`

## Requirements
- R1: Under reset and after it with no request: both strobes high, `ata_cs_n` = 2'b11, `ata_dout_en` = 0, `done`, `busy` and `timeout` low.
- R2: A request taken while idle drives the address and selects (`ata_cs_n` = ~`req_cs`) for S = ceil(setup_ns/CLK_NS) cycles before the strobe falls. The setup_ns for modes 0..6 is 70, 50, 30, 30, 25, 15, 10.
- R3: The strobe stays low for at least A = ceil(active_ns/CLK_NS) cycles. The active_ns for modes 0..6 is 165, 125, 100, 80, 70, 65, 55. When `req_byte` = 1 in modes 0 to 2 it is 290 instead; in modes 3 to 6 `req_byte` has no effect.
- R4: The selects stay asserted for max(ceil(cycle_ns/CLK_NS), S + A_actual + H) cycles. The cycle_ns for modes 0..6 is 600, 383, 240, 180, 120, 100, 80. H = ceil(hold_ns/CLK_NS), with hold_ns 20, 15, 10 in modes 0..2 and 10 above.
- R5: From acceptance to done, the address, the selects and, on a write, `ata_dout` with `ata_dout_en` = 1 stay constant. Only `ata_wr_n` falls on a write and only `ata_rd_n` on a read.
- R6: A read captures `ata_din` on the clock edge that releases the strobe. `rdata` shows it during a single-cycle `done` pulse, one cycle after the selects release. A write leaves `rdata` unchanged.
- R7: In modes 0 to 4 the ready line passes through a 2-stage synchroniser and is sampled after 7 cycles (ceil(35 ns/CLK_NS)) of strobe low. If it is low there, the strobe stays low until it has been seen high. The strobe then rises 3 cycles after the ready line rises, but never before A cycles.
- R8: In modes 5 and 6 the ready line is ignored: a low ready line neither stretches the strobe nor raises `timeout`.
- R9: If the ready line stays low for 250 waiting cycles (ceil(1250 ns/CLK_NS)), the strobe rises after 7 + 250 low cycles and `timeout` is high with `done`. The next accepted request clears it.
- R10: `req_valid` is ignored while `busy`. A mode value of 7 behaves as mode 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Start a transfer (taken when idle) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 8-bit register access |
| req_mode | input | 3 | Transfer mode 0..6 (7 acts as 6) |
| req_addr | input | 3 | Register address |
| req_cs | input | 2 | Active-high chip selects |
| req_wdata | input | 16 | Write data |
| ata_din | input | 16 | Data bus read from the device |
| ata_iordy | input | 1 | Device ready line (low = wait) |
| ata_addr | output | 3 | Address to the device |
| ata_cs_n | output | 2 | Active-low chip selects |
| ata_rd_n | output | 1 | Read strobe, active low |
| ata_wr_n | output | 1 | Write strobe, active low |
| ata_dout | output | 16 | Data bus driven to the device |
| ata_dout_en | output | 1 | Drive enable for `ata_dout` |
| busy | output | 1 | A transfer is in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Captured read data |
| timeout | output | 1 | Last transfer ended on a ready timeout |

## Verification
The hardest cases to reach are the ones where the ready line goes high at a chosen point while the strobe is held: after the minimum active time has passed, before it has passed, or never. The bench holds the ready line low ahead of the request. It counts strobe-low cycles at each falling clock edge and releases the line, together with new bus data, at a chosen count. That lets it check the three-cycle release latency, the floor at the minimum active time, and the 257-cycle timeout path. A separate case pulses a request with a different address in the middle of a transfer, to show that requests are ignored while busy.

// File: rtl/pio_pkg.sv
// Shared types and per-mode timing tables for the programmed-I/O sequencer.
// Assumes modes above 6 are already clipped by the caller (default rows give mode 6).
package pio_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_ACTIVE,
        ST_WAIT,
        ST_RECOV
    } pio_state_t;

    // Round a nanosecond figure up to whole clock periods.
    function automatic int ns_to_cyc(input int ns, input int clk_ns);
        return (ns + clk_ns - 1) / clk_ns;
    endfunction

    function automatic int setup_ns(input logic [2:0] m);
        case (m)
            3'd0:    return 70;
            3'd1:    return 50;
            3'd2:    return 30;
            3'd3:    return 30;
            3'd4:    return 25;
            3'd5:    return 15;
            default: return 10;
        endcase
    endfunction

    function automatic int active_ns(input logic [2:0] m, input logic narrow);
        if (narrow && m <= 3'd2) return 290;
        case (m)
            3'd0:    return 165;
            3'd1:    return 125;
            3'd2:    return 100;
            3'd3:    return 80;
            3'd4:    return 70;
            3'd5:    return 65;
            default: return 55;
        endcase
    endfunction

    function automatic int cycle_ns(input logic [2:0] m);
        case (m)
            3'd0:    return 600;
            3'd1:    return 383;
            3'd2:    return 240;
            3'd3:    return 180;
            3'd4:    return 120;
            3'd5:    return 100;
            default: return 80;
        endcase
    endfunction

    function automatic int hold_ns(input logic [2:0] m);
        case (m)
            3'd0:    return 20;
            3'd1:    return 15;
            default: return 10;
        endcase
    endfunction

endpackage

// File: rtl/pio_mode_timing.sv
// Converts the latched transfer mode into phase lengths in clock cycles.
// Assumes: CLK_NS is the clock period in ns; CW is wide enough for the longest phase.
module pio_mode_timing
    import pio_pkg::*;
#(
    parameter int CLK_NS = 5,
    parameter int CW     = 10
) (
    input  logic [2:0]    mode,
    input  logic          narrow,
    output logic [CW-1:0] setup_c,
    output logic [CW-1:0] act_c,
    output logic [CW-1:0] cyc_c,
    output logic [CW-1:0] hold_c,
    output logic          use_rdy
);

    logic [2:0] m_eff;

    // Clip the unused mode code onto the fastest mode and look up each phase.
    always_comb begin
        m_eff   = (mode > 3'd6) ? 3'd6 : mode;
        setup_c = CW'(ns_to_cyc(setup_ns(m_eff), CLK_NS));
        act_c   = CW'(ns_to_cyc(active_ns(m_eff, narrow), CLK_NS));
        cyc_c   = CW'(ns_to_cyc(cycle_ns(m_eff), CLK_NS));
        hold_c  = CW'(ns_to_cyc(hold_ns(m_eff), CLK_NS));
        use_rdy = (m_eff <= 3'd4);
    end

endmodule

// File: rtl/pio_rdy_sync.sv
// Multi-stage synchroniser for the asynchronous device ready line.
// Assumes STAGES >= 2; resets to "ready" so nothing waits straight out of reset.
module pio_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rdy_async,
    output logic rdy_s
);

    logic [STAGES-1:0] sh;

    // Shift the raw line through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sh <= '1;
        else        sh <= {sh[STAGES-2:0], rdy_async};
    end

    assign rdy_s = sh[STAGES-1];

endmodule

// File: rtl/pio_cycle_fsm.sv
// Phase sequencer: setup, strobe active (with optional ready wait), recovery.
// Assumes the phase lengths come from pio_mode_timing for the latched mode and
// that TA_CYC is smaller than every active length.
module pio_cycle_fsm
    import pio_pkg::*;
#(
    parameter int DW      = 16,
    parameter int AW      = 3,
    parameter int CW      = 10,
    parameter int TA_CYC  = 7,
    parameter int TMO_CYC = 250
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_byte,
    input  logic [2:0]    req_mode,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_cs,
    input  logic [DW-1:0] req_wdata,
    input  logic [CW-1:0] setup_c,
    input  logic [CW-1:0] act_c,
    input  logic [CW-1:0] cyc_c,
    input  logic [CW-1:0] hold_c,
    input  logic          use_rdy,
    input  logic          rdy_s,
    input  logic [DW-1:0] ata_din,
    output logic [2:0]    mode_q,
    output logic          byte_q,
    output logic [AW-1:0] ata_addr,
    output logic [1:0]    ata_cs_n,
    output logic          ata_rd_n,
    output logic          ata_wr_n,
    output logic [DW-1:0] ata_dout,
    output logic          ata_dout_en,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          timeout
);

    pio_state_t    state;
    logic          wr_q;
    logic [CW-1:0] ph_cnt, act_cnt, wait_cnt, tot_cnt;
    logic          act_met;

    assign act_met = (act_cnt >= act_c - CW'(1));
    assign busy    = (state != ST_IDLE);

    // Main sequencer: walks the phases and drives every bus output from flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            wr_q        <= 1'b0;
            mode_q      <= '0;
            byte_q      <= 1'b0;
            ph_cnt      <= '0;
            act_cnt     <= '0;
            wait_cnt    <= '0;
            tot_cnt     <= '0;
            ata_addr    <= '0;
            ata_cs_n    <= 2'b11;
            ata_rd_n    <= 1'b1;
            ata_wr_n    <= 1'b1;
            ata_dout    <= '0;
            ata_dout_en <= 1'b0;
            done        <= 1'b0;
            rdata       <= '0;
            timeout     <= 1'b0;
        end else begin
            done <= 1'b0;
            if (state != ST_IDLE) tot_cnt <= tot_cnt + CW'(1);
            case (state)
                ST_IDLE: if (req_valid) begin
                    state       <= ST_SETUP;
                    wr_q        <= req_write;
                    mode_q      <= req_mode;
                    byte_q      <= req_byte;
                    ata_addr    <= req_addr;
                    ata_cs_n    <= ~req_cs;
                    ata_dout    <= req_wdata;
                    ata_dout_en <= req_write;
                    ph_cnt      <= '0;
                    tot_cnt     <= '0;
                    timeout     <= 1'b0;
                end
                ST_SETUP: begin
                    if (ph_cnt == setup_c - CW'(1)) begin
                        state    <= ST_ACTIVE;
                        act_cnt  <= '0;
                        ata_rd_n <= wr_q;
                        ata_wr_n <= !wr_q;
                    end else begin
                        ph_cnt <= ph_cnt + CW'(1);
                    end
                end
                ST_ACTIVE: begin
                    act_cnt <= act_cnt + CW'(1);
                    if (use_rdy && act_cnt == CW'(TA_CYC - 1) && !rdy_s) begin
                        state    <= ST_WAIT;
                        wait_cnt <= '0;
                    end else if (act_met) begin
                        state    <= ST_RECOV;
                        ph_cnt   <= '0;
                        ata_rd_n <= 1'b1;
                        ata_wr_n <= 1'b1;
                        if (!wr_q) rdata <= ata_din;
                    end
                end
                ST_WAIT: begin
                    act_cnt <= act_cnt + CW'(1);
                    if (rdy_s && !act_met) begin
                        state <= ST_ACTIVE;
                    end else if (rdy_s || wait_cnt == CW'(TMO_CYC - 1)) begin
                        state    <= ST_RECOV;
                        ph_cnt   <= '0;
                        ata_rd_n <= 1'b1;
                        ata_wr_n <= 1'b1;
                        timeout  <= !rdy_s;
                        if (!wr_q) rdata <= ata_din;
                    end else begin
                        wait_cnt <= wait_cnt + CW'(1);
                    end
                end
                ST_RECOV: begin
                    ph_cnt <= ph_cnt + CW'(1);
                    if (ph_cnt >= hold_c - CW'(1) && tot_cnt >= cyc_c - CW'(1)) begin
                        state       <= ST_IDLE;
                        done        <= 1'b1;
                        ata_cs_n    <= 2'b11;
                        ata_dout_en <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R5: the two strobes are never low together.
    p_one_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(!ata_rd_n && !ata_wr_n));

    // R5: address held for the whole transfer.
    p_addr_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(ata_addr));

    // R3: a strobe release never comes before the mode's active length.
    p_active_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ata_rd_n) || $rose(ata_wr_n)) |-> (act_cnt >= act_c));

    // R4: completion only once the full cycle length has elapsed.
    p_cycle_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (tot_cnt >= cyc_c));

    // R6: done is a single-cycle pulse.
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: the ready wait is entered only in modes that honour the ready line.
    p_wait_mode_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT) |-> use_rdy);

    // R9: a timeout is only reported in modes that honour the ready line.
    p_timeout_mode_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && timeout) |-> use_rdy);

endmodule

// File: rtl/pio_cycle_ctrl.sv
// Top of the programmed-I/O host cycle controller: mode timing lookup,
// ready-line synchroniser and the phase sequencer.
// Assumes one outstanding request at a time; requests while busy are dropped.
module pio_cycle_ctrl #(
    parameter int CLK_NS          = 5,
    parameter int IORDY_SAMPLE_NS = 35,
    parameter int IORDY_MAX_NS    = 1250,
    parameter int SYNC_STAGES     = 2,
    parameter int DW              = 16,
    parameter int AW              = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic          req_byte,
    input  logic [2:0]    req_mode,
    input  logic [AW-1:0] req_addr,
    input  logic [1:0]    req_cs,
    input  logic [DW-1:0] req_wdata,
    input  logic [DW-1:0] ata_din,
    input  logic          ata_iordy,
    output logic [AW-1:0] ata_addr,
    output logic [1:0]    ata_cs_n,
    output logic          ata_rd_n,
    output logic          ata_wr_n,
    output logic [DW-1:0] ata_dout,
    output logic          ata_dout_en,
    output logic          busy,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          timeout
);

    localparam int TA_CYC  = (IORDY_SAMPLE_NS + CLK_NS - 1) / CLK_NS;
    localparam int TMO_CYC = (IORDY_MAX_NS + CLK_NS - 1) / CLK_NS;
    localparam int MAX_CYC = (600 + CLK_NS - 1) / CLK_NS;
    localparam int CW      = $clog2(TA_CYC + TMO_CYC + 2 * MAX_CYC) + 1;

    logic [2:0]    mode_q;
    logic          byte_q;
    logic [CW-1:0] setup_c, act_c, cyc_c, hold_c;
    logic          use_rdy;
    logic          rdy_s;

    pio_mode_timing #(.CLK_NS(CLK_NS), .CW(CW)) u_timing (
        .mode    (mode_q),
        .narrow  (byte_q),
        .setup_c (setup_c),
        .act_c   (act_c),
        .cyc_c   (cyc_c),
        .hold_c  (hold_c),
        .use_rdy (use_rdy)
    );

    pio_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .rdy_async (ata_iordy),
        .rdy_s     (rdy_s)
    );

    pio_cycle_fsm #(
        .DW(DW), .AW(AW), .CW(CW), .TA_CYC(TA_CYC), .TMO_CYC(TMO_CYC)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_byte    (req_byte),
        .req_mode    (req_mode),
        .req_addr    (req_addr),
        .req_cs      (req_cs),
        .req_wdata   (req_wdata),
        .setup_c     (setup_c),
        .act_c       (act_c),
        .cyc_c       (cyc_c),
        .hold_c      (hold_c),
        .use_rdy     (use_rdy),
        .rdy_s       (rdy_s),
        .ata_din     (ata_din),
        .mode_q      (mode_q),
        .byte_q      (byte_q),
        .ata_addr    (ata_addr),
        .ata_cs_n    (ata_cs_n),
        .ata_rd_n    (ata_rd_n),
        .ata_wr_n    (ata_wr_n),
        .ata_dout    (ata_dout),
        .ata_dout_en (ata_dout_en),
        .busy        (busy),
        .done        (done),
        .rdata       (rdata),
        .timeout     (timeout)
    );

    // R1: selects and strobes idle whenever no transfer is in progress.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (ata_cs_n == 2'b11 && ata_rd_n && ata_wr_n));

endmodule

// File: tb/pio_cycle_ctrl_test.sv
`timescale 1ns/1ps
module pio_cycle_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_byte = 1'b0;
    logic [2:0]  req_mode = 3'd0, req_addr = 3'd0;
    logic [1:0]  req_cs = 2'b00;
    logic [15:0] req_wdata = 16'h0, ata_din = 16'h0;
    logic        ata_iordy = 1'b1;
    logic [2:0]  ata_addr;
    logic [1:0]  ata_cs_n;
    logic        ata_rd_n, ata_wr_n, ata_dout_en, busy, done, timeout;
    logic [15:0] ata_dout, rdata;

    int n_chk = 0, n_fail = 0;

    always #2.5 clk = ~clk;

    pio_cycle_ctrl uut (.*);

    // Per vector: {mode[3], write, byte, S[8], A[8], T[8]} in clock cycles at 5 ns.
    localparam int NV = 10;
    localparam logic [28:0] VEC [NV] = '{
        {3'd0, 1'b0, 1'b0, 8'd14, 8'd33,  8'd120},
        {3'd1, 1'b1, 1'b0, 8'd10, 8'd25,  8'd77},
        {3'd2, 1'b0, 1'b1, 8'd6,  8'd58,  8'd66},
        {3'd3, 1'b1, 1'b0, 8'd6,  8'd16,  8'd36},
        {3'd4, 1'b0, 1'b0, 8'd5,  8'd14,  8'd24},
        {3'd5, 1'b1, 1'b0, 8'd3,  8'd13,  8'd20},
        {3'd6, 1'b0, 1'b0, 8'd2,  8'd11,  8'd16},
        {3'd0, 1'b1, 1'b1, 8'd14, 8'd58,  8'd120},
        {3'd3, 1'b0, 1'b1, 8'd6,  8'd16,  8'd36},
        {3'd7, 1'b0, 1'b0, 8'd2,  8'd11,  8'd16}
    };

    // Results of the last transfer, measured at falling edges.
    int          r_s, r_a, r_t;
    logic [15:0] r_rd;
    logic        r_tmo, r_ok, r_pulse_ok;
    int          rel_at = -1;
    logic [15:0] rel_din = 16'h0;
    logic        poke = 1'b0;
    logic        dog = 1'b0;

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic run_one(input logic [2:0] m, input logic wr, input logic byt,
                           input logic [2:0] ad, input logic [1:0] cs, input logic [15:0] wd);
        logic strobe;
        @(negedge clk);
        req_mode = m; req_write = wr; req_byte = byt; req_addr = ad; req_cs = cs;
        req_wdata = wd; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        r_s = 0; r_a = 0; r_t = 0; r_ok = 1'b1;
        for (int k = 0; k < 3000; k++) begin
            if (done) break;
            if (k == 2999) begin
                dog = 1'b1;
            end
            if (ata_cs_n != 2'b11) r_t++;
            if (ata_addr != ad || ata_cs_n != ~cs) r_ok = 1'b0;
            if (wr && (ata_dout != wd || !ata_dout_en || !ata_rd_n)) r_ok = 1'b0;
            if (!wr && (ata_dout_en || !ata_wr_n)) r_ok = 1'b0;
            strobe = wr ? ata_wr_n : ata_rd_n;
            if (!strobe) begin
                r_a++;
                if (r_a == rel_at) begin
                    ata_iordy = 1'b1;
                    ata_din = rel_din;
                end
            end else if (r_a == 0) begin
                r_s++;
            end
            if (poke && r_t == 5) begin req_valid = 1'b1; req_addr = ~ad; end
            if (poke && r_t == 6) begin req_valid = 1'b0; req_addr = ad; end
            @(negedge clk);
        end
        r_rd = rdata;
        r_tmo = timeout;
        @(negedge clk);
        r_pulse_ok = !done && !busy;
    endtask

    // Watchdog: a hung run is counted as a failure and still reaches the summary.
    initial begin
        #(5 * 190000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] last_rd;
        // R1: reset state, during and after reset.
        repeat (3) @(negedge clk);
        chk("R1 cs_n in reset", int'(ata_cs_n), 3);
        chk("R1 strobes in reset", int'({ata_rd_n, ata_wr_n}), 3);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 idle outputs", int'({ata_dout_en, done, busy, timeout}), 0);
        chk("R1 idle strobes/cs", int'({ata_cs_n, ata_rd_n, ata_wr_n}), 15);
        last_rd = rdata;

        // Vector table: R2 R3 R4 R5 R6 R10 with the ready line high.
        for (int i = 0; i < NV; i++) begin
            logic [28:0] v;
            v = VEC[i];
            ata_din = 16'h1000 + 16'(i * 16'h0111);
            run_one(v[28:26], v[25], v[24], 3'(i), 2'(i % 3 + 1), 16'hC000 + 16'(i));
            chk($sformatf("R2 setup cycles vec%0d", i), r_s, int'(v[23:16]));
            chk($sformatf("R3 active cycles vec%0d", i), r_a, int'(v[15:8]));
            chk($sformatf("R4 total cycles vec%0d", i), r_t, int'(v[7:0]));
            chk($sformatf("R5 bus stable vec%0d", i), int'(r_ok), 1);
            chk($sformatf("R6 done pulse vec%0d", i), int'(r_pulse_ok), 1);
            if (!v[25]) last_rd = 16'h1000 + 16'(i * 16'h0111);
            chk($sformatf("R6 rdata vec%0d", i), int'(r_rd), int'(last_rd));
            chk($sformatf("R9 no timeout vec%0d", i), int'(r_tmo), 0);
        end

        // R7: ready low at the sample point, released after the minimum active time.
        ata_iordy = 1'b0; ata_din = 16'h0BAD;
        rel_at = 30; rel_din = 16'hA5C3;
        run_one(3'd2, 1'b0, 1'b0, 3'd5, 2'b01, 16'h0);
        chk("R7 release latency active", r_a, 32);
        chk("R7 rdata after ready", int'(r_rd), 16'hA5C3);
        chk("R7 total", r_t, 48);
        chk("R7 no timeout", int'(r_tmo), 0);

        // R7: ready released early does not shorten the minimum active time.
        ata_iordy = 1'b0; rel_at = 10; rel_din = 16'h5A5A;
        run_one(3'd0, 1'b0, 1'b0, 3'd2, 2'b10, 16'h0);
        chk("R7 early release keeps min active", r_a, 33);
        chk("R7 early release total", r_t, 120);

        // R9: ready never returns: timeout after 7 + 250 low cycles.
        ata_iordy = 1'b0; rel_at = -1;
        run_one(3'd1, 1'b1, 1'b0, 3'd6, 2'b11, 16'h7E81);
        chk("R9 timeout active", r_a, 257);
        chk("R9 timeout total", r_t, 270);
        chk("R9 timeout flag", int'(r_tmo), 1);
        chk("R9 write keeps rdata", int'(r_rd), 16'h5A5A);

        // R9: next accepted request clears the flag.
        ata_iordy = 1'b1; ata_din = 16'h3C3C;
        run_one(3'd1, 1'b0, 1'b0, 3'd1, 2'b01, 16'h0);
        chk("R9 flag cleared", int'(r_tmo), 0);
        chk("R9 normal active after timeout", r_a, 25);

        // R8: fast modes ignore a low ready line.
        ata_iordy = 1'b0;
        run_one(3'd5, 1'b0, 1'b0, 3'd3, 2'b01, 16'h0);
        chk("R8 mode5 active", r_a, 13);
        chk("R8 mode5 total", r_t, 20);
        chk("R8 mode5 no timeout", int'(r_tmo), 0);
        ata_iordy = 1'b1;

        // R10: a request pulsed while busy is dropped.
        poke = 1'b1;
        run_one(3'd4, 1'b0, 1'b0, 3'd4, 2'b10, 16'h0);
        poke = 1'b0;
        chk("R10 busy request ignored (address)", int'(r_ok), 1);
        chk("R10 busy request ignored (total)", r_t, 24);
        chk("R10 no second transfer", int'(r_pulse_ok), 1);
        repeat (4) @(negedge clk);
        chk("R10 stays idle", int'(busy), 0);

        if (dog) begin
            n_chk++; n_fail++;
            $display("FAIL R6 done: actual missing expected pulse");
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule